// File: doc/BRIEF.md
# Controller status and interrupt register

This block is the host-visible 16-bit status and control word of a communications controller that moves frames through descriptor rings in memory. It keeps a run flag for each direction and an interrupt enable. It also keeps a summary interrupt flag and seven latched event bits, and from these it drives an active-low interrupt pin. The ring engines, FIFOs and bus logic are not part of the block. They appear only as single-cycle event pulses and a few bus-cycle status inputs.

The host writes the word with a one-cycle strobe. Event bits are cleared by writing 1 to them. The run flags follow Start and Stop primitive pulses and the per-direction disable inputs. A built-in bus watchdog counts clocks while the controller, as bus master, waits for ready. When the limit is reached it latches a memory error, halts both directions and pulses a bus-release output. The synchronous reset input acts as the bus reset.

Top module: `ctl_stat_reg`

## Requirements
- R1: Bit 11 (transmit run) sets one clock after a Start pulse while `tx_dis` is 0. While not in the stopped phase, it also sets one clock after `tx_dis` falls from 1 to 0. It clears one clock after any cycle in which `tx_dis` is 1, Stop is pulsed, reset is high or the watchdog fires, and clearing takes priority over setting.
- R2: Bit 10 (receive run) obeys the R1 rules, using `rx_dis` in place of `tx_dis`.
- R3: The event bits are bit 7 memory error, bit 6 missed frame, bit 5 receive overrun, bit 4 transmit underrun, bit 3 primitive, bit 2 transmit ring update and bit 1 receive ring update. Each sets one clock after its pulse. A host write with a 1 in that bit position clears it, and a write with a 0 leaves it unchanged.
- R4: A Stop pulse or reset clears bits 11 down to 1 on the next clock and puts the block into the stopped phase. The stopped phase ends on the clock after a Start pulse, and Stop wins when both arrive in the same cycle.
- R5: Bit 9 (interrupt enable) takes the value written to it. A write of 1 made while in the stopped phase leaves it at 0.
- R6: Host writes to bits 11, 10, 8, 0 and 15..12 have no effect. Bit 0 and bits 15..12 always read 0.
- R7: Bit 8 (summary) is 1 exactly when any of bits 7, 6, 3, 2 or 1 is 1. Bits 5 and 4 do not affect it, and it falls in the same cycle as the last of those bits clears.
- R8: `irq_n` is 0 exactly when bits 9 and 8 are both 1, and is 1 otherwise.
- R9: While `bm_wait` is high, the watchdog counts the clocks that have no `bm_ready` and no `bm_start`. Either of those inputs, or `bm_wait` low, restarts the count. On the TIMEOUT_CLKS-th counted clock after a `bm_start`, bit 7 sets, bits 11 and 10 clear and `bus_release` is high for one cycle.
- R10: When an event pulse and a host write-1 clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high bus reset |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_data | input | 16 | Host write data |
| start_p | input | 1 | Start primitive pulse |
| stop_p | input | 1 | Stop primitive pulse |
| tx_dis | input | 1 | Transmit disable level |
| rx_dis | input | 1 | Receive disable level |
| ev_missed | input | 1 | Missed frame pulse |
| ev_rx_ovr | input | 1 | Receive overrun pulse |
| ev_tx_und | input | 1 | Transmit underrun pulse |
| ev_prim | input | 1 | Primitive register update pulse |
| ev_tx_ring | input | 1 | Transmit ring entry update pulse |
| ev_rx_ring | input | 1 | Receive ring entry update pulse |
| bm_wait | input | 1 | Bus master cycle in progress, awaiting ready |
| bm_start | input | 1 | New bus cycle, address presented |
| bm_ready | input | 1 | Ready returned by memory |
| csr_q | output | 16 | Status word as read by the host |
| irq_n | output | 1 | Active-low interrupt pin |
| bus_release | output | 1 | One-cycle pulse telling the bus logic to let go after a timeout |

## Verification
The properties assume that every input is synchronous to `clk`. They also assume that the cycle after reset deasserts is the first in which history is examined, so a `$past` of Stop taken there reads a value sampled while reset was still high. The stimulus keeps the event and primitive inputs to one-cycle pulses driven away from the clock edge. It raises `bm_start` only while `bm_wait` is high, and it drops `bm_wait` after each bus episode, so the watchdog never sees a ready pulse without a bus cycle in progress.

// File: rtl/csr_stat_pkg.sv
package csr_stat_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned N_EVT  = 7;
  // positions in the host-visible word
  localparam int unsigned P_TXON = 11;
  localparam int unsigned P_RXON = 10;
  localparam int unsigned P_IEN  = 9;
  localparam int unsigned P_SUM  = 8;
  localparam int unsigned P_EVLO = 1;
  // index inside the event vector (word bit = index + P_EVLO)
  localparam int unsigned E_MERR = 6;
  // events that feed the summary flag: merr, missed, prim, tx ring, rx ring
  localparam logic [N_EVT-1:0] SUM_MASK = 7'b1100111;
endpackage

// File: rtl/csr_run_flag.sv
module csr_run_flag (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  input  logic kill,
  input  logic stopped,
  input  logic dis,
  output logic on
);
  logic dis_q;

  always_ff @(posedge clk) begin
    dis_q <= dis;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on <= 1'b0;
    end else if (stop || kill || dis) begin
      on <= 1'b0;
    end else if (start || (dis_q && !stopped)) begin
      on <= 1'b1;
    end
  end
endmodule

// File: rtl/csr_evt_bank.sv
module csr_evt_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        q[i] <= 1'b0;
      end else if (set[i]) begin
        q[i] <= 1'b1;
      end else if (clr[i]) begin
        q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/csr_bus_wdog.sv
module csr_bus_wdog #(
  parameter int unsigned LIMIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_i,
  input  logic start_i,
  input  logic ready_i,
  output logic fire,
  output logic release_q
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign fire = wait_i && !ready_i && !start_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      release_q <= 1'b0;
    end else begin
      release_q <= fire;
      if (!wait_i || ready_i || start_i || fire) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_stat_reg.sv
module ctl_stat_reg
  import csr_stat_pkg::*;
#(
  parameter int unsigned TIMEOUT_CLKS = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic             tx_dis,
  input  logic             rx_dis,
  input  logic             ev_missed,
  input  logic             ev_rx_ovr,
  input  logic             ev_tx_und,
  input  logic             ev_prim,
  input  logic             ev_tx_ring,
  input  logic             ev_rx_ring,
  input  logic             bm_wait,
  input  logic             bm_start,
  input  logic             bm_ready,
  output logic [REG_W-1:0] csr_q,
  output logic             irq_n,
  output logic             bus_release
);
  logic             stopped;
  logic             ien;
  logic             tmo;
  logic             tx_on, rx_on;
  logic             summary;
  logic [N_EVT-1:0] ev_set, ev_clr, ev_q;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:P_IEN+1], wr_data[P_SUM], wr_data[0]};

  // stopped phase: from reset or Stop until Start; Stop wins a tie
  always_ff @(posedge clk) begin
    if (rst || stop_p) begin
      stopped <= 1'b1;
    end else if (start_p) begin
      stopped <= 1'b0;
    end
  end

  // interrupt enable: plain read/write, setting refused while stopped
  always_ff @(posedge clk) begin
    if (rst || stop_p) begin
      ien <= 1'b0;
    end else if (wr_en) begin
      ien <= wr_data[P_IEN] && !stopped;
    end
  end

  csr_bus_wdog #(.LIMIT(TIMEOUT_CLKS)) u_wdog (
    .clk       (clk),
    .rst       (rst),
    .wait_i    (bm_wait),
    .start_i   (bm_start),
    .ready_i   (bm_ready),
    .fire      (tmo),
    .release_q (bus_release)
  );

  csr_run_flag u_tx (
    .clk (clk), .rst (rst), .start (start_p), .stop (stop_p),
    .kill (tmo), .stopped (stopped), .dis (tx_dis), .on (tx_on)
  );

  csr_run_flag u_rx (
    .clk (clk), .rst (rst), .start (start_p), .stop (stop_p),
    .kill (tmo), .stopped (stopped), .dis (rx_dis), .on (rx_on)
  );

  assign ev_set = {tmo, ev_missed, ev_rx_ovr, ev_tx_und, ev_prim, ev_tx_ring, ev_rx_ring};
  assign ev_clr = wr_en ? wr_data[P_EVLO +: N_EVT] : '0;

  csr_evt_bank #(.N(N_EVT)) u_evt (
    .clk   (clk),
    .rst   (rst),
    .flush (stop_p),
    .set   (ev_set),
    .clr   (ev_clr),
    .q     (ev_q)
  );

  assign summary = |(ev_q & SUM_MASK);
  assign irq_n   = !(ien && summary);

  always_comb begin
    csr_q                     = '0;
    csr_q[P_TXON]             = tx_on;
    csr_q[P_RXON]             = rx_on;
    csr_q[P_IEN]              = ien;
    csr_q[P_SUM]              = summary;
    csr_q[P_EVLO +: N_EVT]    = ev_q;
  end
endmodule

// File: rtl/ctl_stat_reg_chk.sv
module ctl_stat_reg_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        stop_p,
  input logic        tx_dis,
  input logic        rx_dis,
  input logic        ev_prim,
  input logic [15:0] csr_q,
  input logic        irq_n,
  input logic        bus_release
);
  a_r1_txdis_clears: assert property (@(posedge clk) disable iff (rst)
    tx_dis |=> !csr_q[11]);

  a_r2_rxdis_clears: assert property (@(posedge clk) disable iff (rst)
    rx_dis |=> !csr_q[10]);

  a_r3_w1c_prim: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[3] && !ev_prim) |=> !csr_q[3]);

  a_r4_stop_clears: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> (csr_q[11:1] == 11'd0));

  a_r5_ien_by_write: assert property (@(posedge clk) disable iff (rst)
    $rose(csr_q[9]) |-> ($past(wr_en) && $past(wr_data[9])));

  a_r8_irq_low: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (csr_q[9] && csr_q[8]));

  a_r9_timeout_halts: assert property (@(posedge clk) disable iff (rst)
    (bus_release && !$past(stop_p)) |-> (csr_q[7] && !csr_q[11] && !csr_q[10]));

  a_r9_release_pulse: assert property (@(posedge clk) disable iff (rst)
    bus_release |=> !bus_release);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ev_prim && !stop_p) |=> csr_q[3]);
endmodule

bind ctl_stat_reg ctl_stat_reg_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .stop_p      (stop_p),
  .tx_dis      (tx_dis),
  .rx_dis      (rx_dis),
  .ev_prim     (ev_prim),
  .csr_q       (csr_q),
  .irq_n       (irq_n),
  .bus_release (bus_release)
);

// File: tb/tb_ctl_stat_reg.sv
module tb_ctl_stat_reg;
  localparam int LIM = 256;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1, wr_en = 1'b0, start_p = 1'b0, stop_p = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic        tx_dis = 1'b0, rx_dis = 1'b1;
  logic        ev_missed = 0, ev_rx_ovr = 0, ev_tx_und = 0, ev_prim = 0, ev_tx_ring = 0, ev_rx_ring = 0;
  logic        bm_wait = 0, bm_start = 0, bm_ready = 0;
  logic [15:0] csr_q;
  logic        irq_n, bus_release;

  ctl_stat_reg #(.TIMEOUT_CLKS(LIM)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .start_p(start_p), .stop_p(stop_p), .tx_dis(tx_dis), .rx_dis(rx_dis),
    .ev_missed(ev_missed), .ev_rx_ovr(ev_rx_ovr), .ev_tx_und(ev_tx_und),
    .ev_prim(ev_prim), .ev_tx_ring(ev_tx_ring), .ev_rx_ring(ev_rx_ring),
    .bm_wait(bm_wait), .bm_start(bm_start), .bm_ready(bm_ready),
    .csr_q(csr_q), .irq_n(irq_n), .bus_release(bus_release)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_tx, m_rx, m_stopped, m_ien, m_rel, m_ptx, m_prx;
  bit [7:1] m_ev;
  int       m_wait_cnt;

  function automatic bit m_sum();
    return m_ev[7] | m_ev[6] | m_ev[3] | m_ev[2] | m_ev[1];
  endfunction

  function automatic logic [15:0] m_word();
    logic [15:0] w = 16'h0;
    w[11] = m_tx; w[10] = m_rx; w[9] = m_ien; w[8] = m_sum();
    w[7:1] = m_ev;
    return w;
  endfunction

  always @(posedge clk) begin
    bit       to;
    bit [7:1] hw;
    bit       ntx, nrx;
    if (rst) begin
      m_tx = 0; m_rx = 0; m_ien = 0; m_ev = '0; m_stopped = 1;
      m_wait_cnt = 0; m_rel = 0;
    end else begin
      to = 0;
      if (bm_wait && !bm_ready && !bm_start) begin
        m_wait_cnt++;
        if (m_wait_cnt == LIM) begin to = 1; m_wait_cnt = 0; end
      end else begin
        m_wait_cnt = 0;
      end
      m_rel = to;
      hw = {to, ev_missed, ev_rx_ovr, ev_tx_und, ev_prim, ev_tx_ring, ev_rx_ring};
      for (int b = 1; b <= 7; b++) begin
        if (wr_en && wr_data[b]) m_ev[b] = 0;
        if (hw[b]) m_ev[b] = 1;
      end
      if (wr_en) m_ien = wr_data[9] && !m_stopped;
      ntx = m_tx; nrx = m_rx;
      if (start_p && !tx_dis) ntx = 1;
      if (start_p && !rx_dis) nrx = 1;
      if (!m_stopped && m_ptx && !tx_dis) ntx = 1;
      if (!m_stopped && m_prx && !rx_dis) nrx = 1;
      if (tx_dis || to) ntx = 0;
      if (rx_dis || to) nrx = 0;
      m_tx = ntx; m_rx = nrx;
      if (start_p) m_stopped = 0;
      if (stop_p) begin
        m_stopped = 1; m_tx = 0; m_rx = 0; m_ien = 0; m_ev = '0;
      end
    end
    m_ptx = tx_dis; m_prx = rx_dis;
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R1", "model tx run", {15'd0, csr_q[11]}, {15'd0, m_word()[11]});
      chk("R2", "model rx run", {15'd0, csr_q[10]}, {15'd0, m_word()[10]});
      chk("R5", "model ien",    {15'd0, csr_q[9]},  {15'd0, m_word()[9]});
      chk("R7", "model summary",{15'd0, csr_q[8]},  {15'd0, m_word()[8]});
      chk("R3", "model events", {9'd0, csr_q[7:1]}, {9'd0, m_word()[7:1]});
      chk("R6", "model zero bits", {11'd0, csr_q[15:12], csr_q[0]}, 16'h0);
      chk("R8", "model irq_n",  {15'd0, irq_n}, {15'd0, !(m_ien && m_sum())});
      chk("R9", "model release",{15'd0, bus_release}, {15'd0, m_rel});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk);
  endtask

  task automatic host_wr(logic [15:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0; wr_data = 16'h0;
  endtask

  task automatic do_start();
    start_p = 1; step(); start_p = 0;
  endtask

  task automatic do_stop();
    stop_p = 1; step(); stop_p = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap;
    int          k;
    bit          seen;
    repeat (3) step();
    rst = 0;
    chk("R4", "reset word", csr_q, 16'h0000);
    chk("R8", "reset irq_n", {15'd0, irq_n}, 16'h0001);

    host_wr(16'h0200);
    chk("R5", "ien write while stopped", {15'd0, csr_q[9]}, 16'h0);

    do_start();
    chk("R1", "start tx_dis=0", {14'd0, csr_q[11:10]}, 16'h0002);
    rx_dis = 0; step();
    chk("R2", "rx_dis falls", {14'd0, csr_q[11:10]}, 16'h0003);

    host_wr(16'h0200);
    chk("R5", "ien write when running", {15'd0, csr_q[9]}, 16'h1);

    ev_tx_und = 1; step(); ev_tx_und = 0;
    chk("R7", "underrun no summary", {14'd0, csr_q[8], irq_n}, 16'h0001);
    chk("R3", "underrun bit4", {15'd0, csr_q[4]}, 16'h1);

    ev_rx_ring = 1; step(); ev_rx_ring = 0;
    chk("R8", "rx ring irq low", {14'd0, csr_q[8], irq_n}, 16'h0002);

    host_wr(16'h0200);
    chk("R3", "write 0 keeps bit1", {15'd0, csr_q[1]}, 16'h1);
    host_wr(16'h0202);
    chk("R7", "summary drops", {13'd0, csr_q[8], csr_q[1], irq_n}, 16'h0001);

    ev_prim = 1; wr_en = 1; wr_data = 16'h0208; step();
    ev_prim = 0; wr_en = 0; wr_data = 0;
    chk("R10", "set beats clear", {15'd0, csr_q[3]}, 16'h1);

    ev_missed = 1; ev_rx_ovr = 1; ev_tx_ring = 1; step();
    ev_missed = 0; ev_rx_ovr = 0; ev_tx_ring = 0;
    chk("R3", "multi events", {9'd0, csr_q[7:1]}, 16'h003E);

    snap = csr_q;
    host_wr(16'hFB01);
    chk("R6", "read-only write", csr_q, snap);

    host_wr(16'h0278);
    chk("R3", "w1c group", {9'd0, csr_q[7:1]}, 16'h0002);

    tx_dis = 1; step();
    chk("R1", "tx_dis clears", {15'd0, csr_q[11]}, 16'h0);
    tx_dis = 0; step();
    chk("R1", "tx_dis falls running", {15'd0, csr_q[11]}, 16'h1);

    // watchdog reload by ready
    bm_wait = 1; bm_start = 1; step(); bm_start = 0;
    seen = 0;
    for (int i = 0; i < 200; i++) begin step(); if (bus_release) seen = 1; end
    bm_ready = 1; step(); bm_ready = 0;
    for (int i = 0; i < 100; i++) begin step(); if (bus_release) seen = 1; end
    bm_wait = 0; step();
    chk("R9", "ready reloads", {15'd0, seen}, 16'h0);
    chk("R9", "no merr", {15'd0, csr_q[7]}, 16'h0);

    // watchdog expiry
    bm_wait = 1; bm_start = 1; k = 0;
    do begin step(); bm_start = 0; k++; end while (!bus_release && k < 400);
    chk("R9", "timeout cycle", k[15:0], 16'(LIM + 1));
    chk("R9", "timeout state", {13'd0, csr_q[11:10], csr_q[7]}, 16'h0001);
    chk("R8", "timeout irq", {15'd0, irq_n}, 16'h0);
    bm_wait = 0; step();
    chk("R9", "release one cycle", {15'd0, bus_release}, 16'h0);

    do_stop();
    chk("R4", "stop clears", csr_q, 16'h0);
    host_wr(16'h0200);
    chk("R5", "ien blocked after stop", {15'd0, csr_q[9]}, 16'h0);

    tx_dis = 1; do_start();
    chk("R1", "start with tx_dis=1", {14'd0, csr_q[11:10]}, 16'h0001);
    ev_prim = 1; stop_p = 1; step(); ev_prim = 0; stop_p = 0;
    chk("R4", "stop beats event", csr_q, 16'h0);
    tx_dis = 0; step();
    chk("R1", "dis falls while stopped", {15'd0, csr_q[11]}, 16'h0);

    do_start(); host_wr(16'h0200); ev_missed = 1; step(); ev_missed = 0;
    rst = 1; step(); rst = 0;
    chk("R4", "bus reset clears", csr_q, 16'h0);
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule